// File: doc/BRIEF.md
# Egress Transmit Queue Scheduler with Slot Gating and Preemption

This block decides which transmit queue of an Ethernet egress port may start sending next. Each queue carries a traffic class code (class A, B, C or best effort). A run-time mode selects one of three rules. Strict priority never interrupts a frame once it has started. Time-slot gating opens each class only inside its own repeating window of a schedule table. Preemptive priority lets a higher-priority queue split a lower-priority frame once enough of that frame has been sent.

The transmitter reports the byte count of the frame it is sending and pulses a completion strobe at the end of each frame or fragment. A synchronized free-running time counter drives the schedule table. The scheduler answers with a one-hot grant, held for the whole transmission, and a one-cycle preempt request. Software programs the schedule entries, the last active entry and the minimum byte count that must be sent before a frame may be preempted.

Top module: `egress_gate_sched`

## Requirements
- R1: After reset, grant_o is all zero and preempt_o is low. The mode is strict priority and the minimum sent length for preemption is 64 bytes.
- R2: When no grant is held, the pending eligible queue with the lowest index is granted one cycle later. grant_o is one-hot and stays unchanged until tx_done_i.
- R3: In strict priority mode (mode_i = 0), a frame is never interrupted. A higher-priority queue that becomes pending leaves grant_o and preempt_o unchanged until tx_done_i.
- R4: In time-slot mode (mode_i = 1), a queue is granted only while bit c of the current slot entry's 4-bit class mask is set. Here c is the queue's class code in qclass_i[2i+1:2i], with 0 = A, 1 = B, 2 = C and 3 = best effort.
- R5: In time-slot mode, a queue is not granted while fewer than GUARD_TICKS ticks remain in the current slot.
- R6: The schedule runs through entries 0 up to the programmed last entry and then wraps to entry 0. Each entry lasts its duration in ticks, and a duration of 0 counts as 1. A tick is any clock edge at which time_i differs from its value at the previous edge. Writing the last-entry register restarts the schedule at entry 0.
- R7: In preemptive mode (mode_i = 2), the lowest-index pending queue with a lower index than the owner can preempt the owner. It does so when tx_bytes_i is at least the minimum length. preempt_o then pulses for one cycle, and grant_o moves to that queue on the same edge.
- R8: No preemption occurs while tx_bytes_i is below the minimum length. The minimum length can be written through cfg_minlen_we_i and cfg_minlen_i.
- R9: On tx_done_i of a preempting frame, the grant returns to the preempted queue on the next edge, ahead of any other pending queue.
- R10: A new value on mode_i takes effect only at an edge where no grant is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | Requested mode: 0 priority, 1 time slot, 2 preemptive (3 treated as 0) |
| pend_i | input | NQ | Per-queue pending flags |
| qclass_i | input | 2*NQ | Class code per queue, 2 bits each |
| time_i | input | TW | Synchronized free-running time counter |
| tx_bytes_i | input | BW | Bytes already sent of the current frame |
| tx_done_i | input | 1 | Current frame or fragment finished |
| cfg_minlen_we_i | input | 1 | Write strobe for minimum preemption length |
| cfg_minlen_i | input | BW | New minimum preemption length |
| cfg_slot_we_i | input | 1 | Write strobe for one schedule entry |
| cfg_slot_idx_i | input | SIW | Entry index to write |
| cfg_slot_dur_i | input | DW | Entry duration in ticks |
| cfg_slot_mask_i | input | 4 | Entry class-enable mask |
| cfg_last_we_i | input | 1 | Write strobe for last active entry (restarts schedule) |
| cfg_last_i | input | SIW | Index of last active entry |
| grant_o | output | NQ | One-hot grant of the owning queue |
| preempt_o | output | 1 | One-cycle request to split the current frame |

## Verification
A wrong slot index or a remaining-tick count that is off by one shows up at the ports as a grant one or more cycles early or late around a slot boundary. The bench therefore pins down the exact cycle of the first grant after a schedule restart, including a zero-length entry and a guarded short entry. A stale owner or suspended-queue register shows up as a grant that fails to return to the preempted queue on the edge after completion, or as a second preemption. A mode register that updates while a grant is held shows up as a preempt pulse in a frame that should have been left whole.

// File: rtl/tsn_sched_pkg.sv
package tsn_sched_pkg;
    typedef enum logic [1:0] {
        MODE_PRIO    = 2'd0,
        MODE_SLOT    = 2'd1,
        MODE_PREEMPT = 2'd2
    } sched_mode_e;

    localparam int unsigned NUM_CLASSES = 4;
    localparam int unsigned CLASS_W     = 2;
endpackage

// File: rtl/tsn_prio_pick.sv
module tsn_prio_pick #(
    parameter int unsigned N  = 4,
    parameter int unsigned IW = 2
) (
    input  logic [N-1:0]  req_i,
    output logic          vld_o,
    output logic [IW-1:0] idx_o
);
    // Lowest index has the highest priority.
    always_comb begin
        vld_o = 1'b0;
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                vld_o = 1'b1;
                idx_o = IW'(i);
            end
        end
    end
endmodule

// File: rtl/tsn_slot_gate.sv
module tsn_slot_gate
    import tsn_sched_pkg::*;
#(
    parameter int unsigned NS      = 8,
    parameter int unsigned DW      = 16,
    parameter int unsigned TW      = 32,
    parameter int unsigned GUARD   = 4,
    parameter int unsigned DEF_DUR = 16,
    localparam int unsigned SIW    = (NS > 1) ? $clog2(NS) : 1
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic [TW-1:0]          time_i,
    input  logic                   slot_we_i,
    input  logic [SIW-1:0]         slot_idx_i,
    input  logic [DW-1:0]          slot_dur_i,
    input  logic [NUM_CLASSES-1:0] slot_mask_i,
    input  logic                   last_we_i,
    input  logic [SIW-1:0]         last_i,
    output logic [NUM_CLASSES-1:0] open_o
);
    typedef struct packed {
        logic [SIW-1:0]                        idx;
        logic [DW-1:0]                         left;
        logic [TW-1:0]                         prev;
        logic [SIW-1:0]                        last;
        logic [NS-1:0][DW-1:0]                 dur;
        logic [NS-1:0][NUM_CLASSES-1:0]        mask;
    } gate_st_t;

    gate_st_t st_d, st_q;
    logic [SIW-1:0] nxt;

    function automatic logic [DW-1:0] eff_dur(input logic [DW-1:0] x);
        return (x == '0) ? DW'(1) : x;
    endfunction

    always_comb begin
        st_d      = st_q;
        nxt       = '0;
        st_d.prev = time_i;
        if (slot_we_i) begin
            st_d.dur[slot_idx_i]  = slot_dur_i;
            st_d.mask[slot_idx_i] = slot_mask_i;
        end
        if (last_we_i) begin
            st_d.last = last_i;
            st_d.idx  = '0;
            st_d.left = eff_dur(st_d.dur[0]);
        end else if (time_i != st_q.prev) begin
            if (st_q.left <= DW'(1)) begin
                nxt       = (st_q.idx == st_q.last) ? '0 : st_q.idx + SIW'(1);
                st_d.idx  = nxt;
                st_d.left = eff_dur(st_d.dur[nxt]);
            end else begin
                st_d.left = st_q.left - DW'(1);
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.idx  <= '0;
            st_q.left <= DW'(DEF_DUR);
            st_q.prev <= '0;
            st_q.last <= SIW'(NS - 1);
            for (int i = 0; i < NS; i++) begin
                st_q.dur[i]  <= DW'(DEF_DUR);
                st_q.mask[i] <= '1;
            end
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_open
        assign open_o[c] = st_q.mask[st_q.idx][c] && (st_q.left >= DW'(GUARD));
    end

    AST_SLOT_LEFT_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.left != '0); // R6
    AST_SLOT_IDX_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.idx <= st_q.last); // R6
    AST_SLOT_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
        last_we_i |=> st_q.idx == '0); // R6
endmodule

// File: rtl/egress_gate_sched.sv
module egress_gate_sched
    import tsn_sched_pkg::*;
#(
    parameter int unsigned NQ        = 4,
    parameter int unsigned NS        = 8,
    parameter int unsigned DW        = 16,
    parameter int unsigned TW        = 32,
    parameter int unsigned BW        = 16,
    parameter int unsigned GUARD     = 4,
    parameter int unsigned MIN_FRAG  = 64,
    localparam int unsigned QIW      = (NQ > 1) ? $clog2(NQ) : 1,
    localparam int unsigned SIW      = (NS > 1) ? $clog2(NS) : 1
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic [1:0]             mode_i,
    input  logic [NQ-1:0]          pend_i,
    input  logic [CLASS_W*NQ-1:0]  qclass_i,
    input  logic [TW-1:0]          time_i,
    input  logic [BW-1:0]          tx_bytes_i,
    input  logic                   tx_done_i,
    input  logic                   cfg_minlen_we_i,
    input  logic [BW-1:0]          cfg_minlen_i,
    input  logic                   cfg_slot_we_i,
    input  logic [SIW-1:0]         cfg_slot_idx_i,
    input  logic [DW-1:0]          cfg_slot_dur_i,
    input  logic [NUM_CLASSES-1:0] cfg_slot_mask_i,
    input  logic                   cfg_last_we_i,
    input  logic [SIW-1:0]         cfg_last_i,
    output logic [NQ-1:0]          grant_o,
    output logic                   preempt_o
);
    typedef struct packed {
        sched_mode_e    mode;
        logic           own_v;
        logic [QIW-1:0] own_idx;
        logic           sus_v;
        logic [QIW-1:0] sus_idx;
        logic           preempt;
        logic [BW-1:0]  minlen;
    } sched_st_t;

    sched_st_t st_d, st_q;

    logic [NUM_CLASSES-1:0] class_open;
    logic [NQ-1:0] gate_ok, elig, own_bit, sus_bit, lower, new_req, pre_req;
    logic          new_v, pre_v;
    logic [QIW-1:0] new_idx, pre_idx;

    tsn_slot_gate #(
        .NS(NS), .DW(DW), .TW(TW), .GUARD(GUARD)
    ) i_slot_gate (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .time_i      (time_i),
        .slot_we_i   (cfg_slot_we_i),
        .slot_idx_i  (cfg_slot_idx_i),
        .slot_dur_i  (cfg_slot_dur_i),
        .slot_mask_i (cfg_slot_mask_i),
        .last_we_i   (cfg_last_we_i),
        .last_i      (cfg_last_i),
        .open_o      (class_open)
    );

    for (genvar i = 0; i < NQ; i++) begin : g_queue
        assign gate_ok[i] = class_open[qclass_i[CLASS_W*i +: CLASS_W]];
        assign elig[i]    = (st_q.mode == MODE_SLOT) ? gate_ok[i] : 1'b1;
        assign own_bit[i] = st_q.own_v && (st_q.own_idx == QIW'(i));
        assign sus_bit[i] = st_q.sus_v && (st_q.sus_idx == QIW'(i));
        assign lower[i]   = st_q.own_v && (QIW'(i) < st_q.own_idx);
        assign grant_o[i] = own_bit[i];
    end

    assign new_req = pend_i & elig & ~own_bit & ~sus_bit;
    assign pre_req = pend_i & lower;

    tsn_prio_pick #(.N(NQ), .IW(QIW)) i_pick_new (
        .req_i (new_req), .vld_o (new_v), .idx_o (new_idx)
    );
    tsn_prio_pick #(.N(NQ), .IW(QIW)) i_pick_pre (
        .req_i (pre_req), .vld_o (pre_v), .idx_o (pre_idx)
    );

    always_comb begin
        st_d         = st_q;
        st_d.preempt = 1'b0;
        if (cfg_minlen_we_i) begin
            st_d.minlen = cfg_minlen_i;
        end
        if (!st_q.own_v) begin
            st_d.mode = (mode_i == 2'd3) ? MODE_PRIO : sched_mode_e'(mode_i);
            if (new_v) begin
                st_d.own_v   = 1'b1;
                st_d.own_idx = new_idx;
            end
        end else if (tx_done_i) begin
            if (st_q.sus_v) begin
                st_d.own_idx = st_q.sus_idx;
                st_d.sus_v   = 1'b0;
            end else begin
                st_d.own_v = 1'b0;
            end
        end else if (st_q.mode == MODE_PREEMPT && !st_q.sus_v && pre_v
                     && tx_bytes_i >= st_q.minlen) begin
            st_d.sus_v   = 1'b1;
            st_d.sus_idx = st_q.own_idx;
            st_d.own_idx = pre_idx;
            st_d.preempt = 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.mode    <= MODE_PRIO;
            st_q.own_v   <= 1'b0;
            st_q.own_idx <= '0;
            st_q.sus_v   <= 1'b0;
            st_q.sus_idx <= '0;
            st_q.preempt <= 1'b0;
            st_q.minlen  <= BW'(MIN_FRAG);
        end else begin
            st_q <= st_d;
        end
    end

    assign preempt_o = st_q.preempt;

    AST_GRANT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(grant_o)); // R2
    AST_GRANT_FROM_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(|grant_o) |-> |($past(pend_i) & grant_o)); // R2
    AST_PRIO_NO_SWITCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(|grant_o) && $past(st_q.mode) == MODE_PRIO && !$past(tx_done_i))
        |-> grant_o == $past(grant_o)); // R3
    AST_SLOT_CLASS_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($rose(|grant_o) && $past(st_q.mode) == MODE_SLOT)
        |-> |($past(gate_ok) & grant_o)); // R4
    AST_PREEMPT_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        preempt_o |-> st_q.mode == MODE_PREEMPT); // R7
    AST_PREEMPT_MIN_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        preempt_o |-> $past(tx_bytes_i) >= $past(st_q.minlen)); // R8
    AST_MODE_HELD_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(|grant_o) && (|grant_o)) |-> $stable(st_q.mode)); // R10
endmodule

// File: tb/test_egress_gate_sched.sv
module test_egress_gate_sched;
    localparam int unsigned NQ = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic [3:0]  pend = '0;
    logic [7:0]  qclass = 8'b11_10_01_00; // q0 A, q1 B, q2 C, q3 best effort
    logic [31:0] tcnt = '0;
    logic [15:0] bytes = '0;
    logic        done = 1'b0;
    logic        ml_we = 1'b0;
    logic [15:0] ml = '0;
    logic        s_we = 1'b0;
    logic [2:0]  s_idx = '0;
    logic [15:0] s_dur = '0;
    logic [3:0]  s_mask = '0;
    logic        l_we = 1'b0;
    logic [2:0]  l_val = '0;
    logic [3:0]  grant;
    logic        preempt;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;
    always @(negedge clk) tcnt <= tcnt + 32'd1;

    egress_gate_sched i_egress_gate_sched (
        .clk_i (clk), .rst_ni (rst_n), .mode_i (mode), .pend_i (pend),
        .qclass_i (qclass), .time_i (tcnt), .tx_bytes_i (bytes), .tx_done_i (done),
        .cfg_minlen_we_i (ml_we), .cfg_minlen_i (ml),
        .cfg_slot_we_i (s_we), .cfg_slot_idx_i (s_idx), .cfg_slot_dur_i (s_dur),
        .cfg_slot_mask_i (s_mask), .cfg_last_we_i (l_we), .cfg_last_i (l_val),
        .grant_o (grant), .preempt_o (preempt)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic chk_g(input string tag, input logic [3:0] exp);
        check(grant === exp, tag, int'(grant), int'(exp));
    endtask

    task automatic chk_p(input string tag, input logic exp);
        check(preempt === exp, tag, int'(preempt), int'(exp));
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk_g("R1 grant in reset", 4'b0000);
        chk_p("R1 preempt in reset", 1'b0);
        rst_n = 1'b1;
        step();
        chk_g("R1 grant after reset", 4'b0000);
        chk_p("R1 preempt after reset", 1'b0);
    endtask

    task automatic t_priority();
        pend = 4'b0110;
        step();
        chk_g("R2 lowest pending granted", 4'b0010);
        pend = 4'b0111; mode = 2'd2; bytes = 16'd200;
        step();
        chk_g("R3 no switch to higher queue", 4'b0010);
        chk_p("R10 mode not applied while busy", 1'b0);
        step();
        chk_g("R3 grant held", 4'b0010);
        chk_p("R3 no preempt in priority mode", 1'b0);
        done = 1'b1;
        step();
        chk_g("R2 released on done", 4'b0000);
        done = 1'b0;
        step();
        chk_g("R2 next lowest pending", 4'b0001);
        chk_p("R3 no preempt pulse", 1'b0);
        pend = 4'b0000; done = 1'b1; bytes = '0;
        step();
        done = 1'b0;
        step();
    endtask

    task automatic t_preempt();
        pend = 4'b0100;
        step();
        chk_g("R7 q2 owns", 4'b0100);
        pend = 4'b0101; bytes = 16'd63;
        step();
        chk_g("R8 no preempt at 63 bytes", 4'b0100);
        chk_p("R8 preempt low at 63", 1'b0);
        bytes = 16'd64;
        step();
        chk_g("R7 grant moves to q0", 4'b0001);
        chk_p("R7 preempt pulse", 1'b1);
        bytes = '0; pend = 4'b0111;
        step();
        chk_p("R7 preempt one cycle", 1'b0);
        chk_g("R7 q1 cannot preempt q0", 4'b0001);
        done = 1'b1; pend = 4'b0110;
        step();
        chk_g("R9 resume preempted q2", 4'b0100);
        pend = 4'b0000;
        step();
        done = 1'b0;
        step();
        chk_g("R9 released", 4'b0000);
    endtask

    task automatic t_minlen();
        ml_we = 1'b1; ml = 16'd100; pend = 4'b0100;
        step();
        ml_we = 1'b0; pend = 4'b0101; bytes = 16'd99;
        step();
        chk_p("R8 programmed length blocks at 99", 1'b0);
        chk_g("R8 q2 kept at 99", 4'b0100);
        bytes = 16'd100;
        step();
        chk_p("R8 preempt at programmed 100", 1'b1);
        bytes = '0; done = 1'b1; pend = 4'b0100;
        step();
        chk_g("R9 resume after minlen test", 4'b0100);
        pend = 4'b0000;
        step();
        done = 1'b0;
        mode = 2'd1;
        step();
    endtask

    task automatic write_slot(input int idx, input int dur, input logic [3:0] m);
        s_we = 1'b1; s_idx = 3'(idx); s_dur = 16'(dur); s_mask = m;
        step();
        s_we = 1'b0;
    endtask

    task automatic restart(input int last);
        l_we = 1'b1; l_val = 3'(last);
        @(posedge clk);
        @(negedge clk);
        l_we = 1'b0;
    endtask

    task automatic t_slot_class();
        write_slot(0, 10, 4'b0010);
        write_slot(1, 10, 4'b0001);
        restart(1);
        pend = 4'b0001;
        for (int k = 1; k <= 22; k++) begin
            step();
            if (k == 10) chk_g("R4 class A closed in B slot", 4'b0000);
            if (k == 11) begin
                chk_g("R4 class A granted in A slot", 4'b0001);
                done = 1'b1; pend = 4'b0000;
            end
            if (k == 12) begin
                done = 1'b0; pend = 4'b0010;
            end
            if (k == 20) chk_g("R4 class B closed in A slot", 4'b0000);
            if (k == 21) begin
                chk_g("R6 wrap to entry 0 grants B", 4'b0010);
                done = 1'b1; pend = 4'b0000;
            end
            if (k == 22) done = 1'b0;
        end
    endtask

    task automatic t_guard();
        write_slot(0, 0, 4'b0001);
        write_slot(1, 3, 4'b0001);
        write_slot(2, 10, 4'b0001);
        restart(2);
        pend = 4'b0001;
        for (int k = 1; k <= 5; k++) begin
            step();
            if (k == 1) chk_g("R6 zero-length entry acts as one tick", 4'b0000);
            if (k == 4) chk_g("R5 guard blocks short slot", 4'b0000);
            if (k == 5) chk_g("R5 granted once slot is long enough", 4'b0001);
        end
        pend = 4'b0000; done = 1'b1;
        step();
        done = 1'b0;
    endtask

    initial begin
        t_reset();
        t_priority();
        t_preempt();
        t_minlen();
        t_slot_class();
        t_guard();
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule